// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit logical address into a physical address by reading a two-level page table held in memory. A caller presents the address, a write flag, the table base and a page-number limit through a valid/ready handshake. The walker first checks the page number against the limit. It then reads the outer entry, which points at an inner table, and then reads the inner entry, which holds the frame number. It returns either the physical address or a fault code.

Only one translation is in flight at a time. Memory is reached through a request/response port: a request is held until the memory accepts it, and a single response word follows at any later cycle. The result stays on the output until the caller acknowledges it.

Top module: `pgw_top`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: The address splits into three fields. The outer index is bits 31:22, the inner index is bits 21:12 and the page offset is bits 11:0. The first memory read goes to `tbl_base + outer_index*4`.
- R3: The second memory read goes to `{outer_entry[31:12], inner_index, 2'b00}`.
- R4: On success, `rsp_fault` is 0 and `rsp_paddr` is `{inner_entry[31:12], offset}`.
- R5: Entry bit 0 is the valid flag and bit 1 is the writable flag. A write to a page whose inner entry is valid and writable succeeds.
- R6: A write to a page whose inner entry has bit 1 clear gives fault code 4 with `rsp_paddr` 0. A read of such a page succeeds, because the writable flag does not affect reads.
- R7: A page number (bits 31:12) greater than `tbl_limit` gives fault code 1 and issues no memory read. A page number equal to the limit is translated.
- R8: An outer entry with bit 0 clear gives fault code 2 after exactly one memory read.
- R9: An inner entry with bit 0 clear gives fault code 3 after exactly two memory reads.
- R10: While `rsp_valid` is 1 and `rsp_ack` is 0, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold. The cycle after the acknowledge, `rsp_valid` is 0 and `req_ready` is 1.
- R11: `req_ready` is 0 from acceptance until the result is acknowledged. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Logical address to translate |
| req_write | input | 1 | Access is a write |
| tbl_base | input | 32 | Byte address of the outer table |
| tbl_limit | input | 20 | Highest permitted page number |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word read from memory |
| rsp_valid | output | 1 | Result present |
| rsp_ack | input | 1 | Caller takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 limit, 2 outer invalid, 3 inner invalid, 4 write protect |

## Verification
If the walker's state went wrong, the memory address log would show it at once. A wrong field split or a wrong table pointer shows up as an unexpected address on the first or second read. A state machine that skips or repeats a level shows up as the wrong number of reads before the result. A bad limit compare shows up as a read that should never have happened. Handshake faults show within a cycle or two: the result changes or drops while the acknowledge is held low, or `req_ready` rises while a walk is still in flight. Each scenario also varies the memory latency, so a response taken before its request was accepted changes the result.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OUTER = 3'd1,
    ST_INNER = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } pgw_state_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_LIMIT = 3'd1,
    FLT_OUTER = 3'd2,
    FLT_INNER = 3'd3,
    FLT_WPROT = 3'd4
  } pgw_fault_e;

  localparam int ENT_VALID_BIT = 0;
  localparam int ENT_WRITE_BIT = 1;

endpackage

// File: rtl/pgw_split.sv
module pgw_split #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IN_W  = 10,
  parameter int OUT_W = 10,
  parameter int ENT_W = 32
) (
  input  logic [VA_W-1:0]         vaddr,
  input  logic [ENT_W-1:0]        base,
  input  logic [OUT_W+IN_W-1:0]   limit,
  output logic [OUT_W-1:0]        outer_idx,
  output logic [IN_W-1:0]         inner_idx,
  output logic [OFF_W-1:0]        offset,
  output logic                    over_limit,
  output logic [ENT_W-1:0]        outer_addr
);
  localparam int VPN_W  = OUT_W + IN_W;
  localparam int ENT_SH = $clog2(ENT_W / 8);

  logic [VPN_W-1:0] vpn;

  always_comb begin
    offset     = vaddr[OFF_W-1:0];
    inner_idx  = vaddr[OFF_W+IN_W-1:OFF_W];
    outer_idx  = vaddr[OFF_W+VPN_W-1:OFF_W+IN_W];
    vpn        = vaddr[OFF_W+VPN_W-1:OFF_W];
    over_limit = (vpn > limit);
    outer_addr = base + (ENT_W'(outer_idx) << ENT_SH);
  end
endmodule

// File: rtl/pgw_entry_eval.sv
module pgw_entry_eval
  import pgw_pkg::*;
#(
  parameter int ENT_W = 32,
  parameter int OFF_W = 12,
  parameter int IN_W  = 10
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             second_level,
  input  logic             write_op,
  input  logic [IN_W-1:0]  inner_idx,
  input  logic [OFF_W-1:0] offset,
  output pgw_fault_e       fault,
  output logic [ENT_W-1:0] next_addr,
  output logic [ENT_W-1:0] phys_addr
);
  localparam int ENT_SH = $clog2(ENT_W / 8);
  localparam int FRM_W  = ENT_W - OFF_W;

  logic [FRM_W-1:0] frame;
  logic             ent_valid;
  logic             ent_write;

  always_comb begin
    frame     = entry[ENT_W-1:OFF_W];
    ent_valid = entry[ENT_VALID_BIT];
    ent_write = entry[ENT_WRITE_BIT];
    next_addr = {frame, {OFF_W{1'b0}}} | (ENT_W'(inner_idx) << ENT_SH);
    phys_addr = {frame, offset};
    if (!ent_valid) begin
      fault = second_level ? FLT_INNER : FLT_OUTER;
    end else if (second_level && write_op && !ent_write) begin
      fault = FLT_WPROT;
    end else begin
      fault = FLT_NONE;
    end
  end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IN_W  = 10,
  parameter int OUT_W = 10,
  parameter int ENT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  input  logic [ENT_W-1:0]       tbl_base,
  input  logic [OUT_W+IN_W-1:0]  tbl_limit,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [ENT_W-1:0]       mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [ENT_W-1:0]       mem_rsp_data,
  output logic                   rsp_valid,
  input  logic                   rsp_ack,
  output logic [ENT_W-1:0]       rsp_paddr,
  output logic [2:0]             rsp_fault
);
  localparam int VPN_W = OUT_W + IN_W;

  pgw_state_e        state;
  logic              lat_write;
  logic [IN_W-1:0]   lat_inner;
  logic [OFF_W-1:0]  lat_offset;

  logic [OUT_W-1:0]  s_outer_idx;
  logic [IN_W-1:0]   s_inner_idx;
  logic [OFF_W-1:0]  s_offset;
  logic              s_over;
  logic [ENT_W-1:0]  s_outer_addr;

  pgw_fault_e        e_fault;
  logic [ENT_W-1:0]  e_next_addr;
  logic [ENT_W-1:0]  e_phys;

  logic              accept;
  logic              rsp_take;

  pgw_split #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IN_W(IN_W), .OUT_W(OUT_W), .ENT_W(ENT_W)
  ) u_split (
    .vaddr      (req_vaddr),
    .base       (tbl_base),
    .limit      (tbl_limit),
    .outer_idx  (s_outer_idx),
    .inner_idx  (s_inner_idx),
    .offset     (s_offset),
    .over_limit (s_over),
    .outer_addr (s_outer_addr)
  );

  pgw_entry_eval #(
    .ENT_W(ENT_W), .OFF_W(OFF_W), .IN_W(IN_W)
  ) u_eval (
    .entry        (mem_rsp_data),
    .second_level (state == ST_INNER),
    .write_op     (lat_write),
    .inner_idx    (lat_inner),
    .offset       (lat_offset),
    .fault        (e_fault),
    .next_addr    (e_next_addr),
    .phys_addr    (e_phys)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_take  = !mem_req_valid && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      lat_write     <= 1'b0;
      lat_inner     <= '0;
      lat_offset    <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_fault     <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            lat_write  <= req_write;
            lat_inner  <= s_inner_idx;
            lat_offset <= s_offset;
            if (s_over) begin
              state     <= ST_FAULT;
              rsp_valid <= 1'b1;
              rsp_paddr <= '0;
              rsp_fault <= FLT_LIMIT;
            end else begin
              state         <= ST_OUTER;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= s_outer_addr;
            end
          end
        end
        ST_OUTER: begin
          if (mem_req_valid) begin
            if (mem_req_ready) mem_req_valid <= 1'b0;
          end else if (rsp_take) begin
            if (e_fault != FLT_NONE) begin
              state     <= ST_FAULT;
              rsp_valid <= 1'b1;
              rsp_paddr <= '0;
              rsp_fault <= e_fault;
            end else begin
              state         <= ST_INNER;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= e_next_addr;
            end
          end
        end
        ST_INNER: begin
          if (mem_req_valid) begin
            if (mem_req_ready) mem_req_valid <= 1'b0;
          end else if (rsp_take) begin
            rsp_valid <= 1'b1;
            if (e_fault != FLT_NONE) begin
              state     <= ST_FAULT;
              rsp_paddr <= '0;
              rsp_fault <= e_fault;
            end else begin
              state     <= ST_DONE;
              rsp_paddr <= e_phys;
              rsp_fault <= FLT_NONE;
            end
          end
        end
        ST_DONE, ST_FAULT: begin
          if (rsp_ack) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^{s_outer_idx, VPN_W[0]};

endmodule

// File: rtl/pgw_checks.sv
module pgw_checks #(
  parameter int ENT_W = 32,
  parameter int VPN_W = 20,
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [31:0]      req_vaddr,
  input logic [VPN_W-1:0] tbl_limit,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [ENT_W-1:0] mem_req_addr,
  input logic             rsp_valid,
  input logic             rsp_ack,
  input logic [ENT_W-1:0] rsp_paddr,
  input logic [2:0]       rsp_fault
);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ack |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ack |=> !rsp_valid && req_ready);

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r11_busy: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  a_r7_no_read: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && (req_vaddr[OFF_W+VPN_W-1:OFF_W] > tbl_limit)
    |=> !mem_req_valid && rsp_valid && rsp_fault == 3'd1);

  a_r6_fault_paddr: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault != 3'd0 |-> rsp_paddr == '0 && rsp_fault <= 3'd4);
endmodule

bind pgw_top pgw_checks #(.ENT_W(ENT_W), .VPN_W(OUT_W+IN_W), .OFF_W(OFF_W)) u_checks (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .tbl_limit(tbl_limit),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .rsp_valid(rsp_valid), .rsp_ack(rsp_ack),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
);

// File: tb/tb_pgw_top.sv
module tb_pgw_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_vaddr, tbl_base;
  logic [19:0] tbl_limit;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rsp_valid, rsp_ack;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_fault;

  int n_chk = 0;
  int n_bad = 0;
  int lat   = 0;
  int rd_cnt;
  logic [31:0] rd_addr [0:3];
  logic [31:0] mem [logic [31:0]];

  always #10 clk = ~clk;

  pgw_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .tbl_base(tbl_base),
    .tbl_limit(tbl_limit), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    rd_cnt = 0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_req_ready = 1'b0;
      if (mem_req_valid && !rst) begin
        repeat (lat) @(negedge clk);
        mem_req_ready = 1'b1;
        if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
        rd_cnt++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = peek(rd_addr[(rd_cnt-1) & 3]);
      end
    end
  end

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic walk(input logic [31:0] va, input logic wr, input logic [19:0] lim,
                      output logic [31:0] pa, output logic [2:0] flt);
    int guard;
    @(negedge clk);
    rd_cnt = 0;
    req_vaddr = va; req_write = wr; tbl_limit = lim; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      check("R11 busy", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
      guard++;
    end
    pa = rsp_paddr; flt = rsp_fault;
    repeat (2) @(negedge clk);
    check("R10 hold valid", {31'b0, rsp_valid}, 32'h1);
    check("R10 hold paddr", rsp_paddr, pa);
    check("R10 hold fault", {29'b0, rsp_fault}, {29'b0, flt});
    check("R11 busy till ack", {31'b0, req_ready}, 32'h0);
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    check("R10 release", {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  localparam logic [31:0] BASE  = 32'h0010_0000;
  localparam logic [31:0] INNER = 32'h0020_0000;

  function automatic logic [31:0] va_of(input int o, input int i, input int off);
    return {o[9:0], i[9:0], off[11:0]};
  endfunction

  task automatic t_reset();
    check("R1 req_ready", {31'b0, req_ready}, 32'h1);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
  endtask

  task automatic t_read_ok();
    logic [31:0] pa; logic [2:0] f;
    lat = 0;
    walk(va_of(3, 5, 12'h0AB), 1'b0, 20'hFFFFF, pa, f);
    check("R2 outer addr", rd_addr[0], BASE + 32'd12);
    check("R3 inner addr", rd_addr[1], INNER + 32'd20);
    check("R4 fault", {29'b0, f}, 32'h0);
    check("R4 paddr", pa, 32'h1234_50AB);
    check("R6 read of ro page", {29'b0, f}, 32'h0);
  endtask

  task automatic t_write_ok();
    logic [31:0] pa; logic [2:0] f;
    lat = 2;
    walk(va_of(3, 6, 12'hFFF), 1'b1, 20'hFFFFF, pa, f);
    check("R5 fault", {29'b0, f}, 32'h0);
    check("R5 paddr", pa, 32'hABCD_EFFF);
    check("R3 inner addr", rd_addr[1], INNER + 32'd24);
  endtask

  task automatic t_write_ro();
    logic [31:0] pa; logic [2:0] f;
    lat = 1;
    walk(va_of(3, 5, 12'h001), 1'b1, 20'hFFFFF, pa, f);
    check("R6 fault", {29'b0, f}, 32'h4);
    check("R6 paddr", pa, 32'h0);
  endtask

  task automatic t_limit();
    logic [31:0] pa; logic [2:0] f;
    lat = 0;
    walk(va_of(3, 5, 12'h0AB), 1'b0, 20'd3076, pa, f);
    check("R7 fault", {29'b0, f}, 32'h1);
    check("R7 no read", rd_cnt, 32'd0);
    walk(va_of(3, 5, 12'h0AB), 1'b0, 20'd3077, pa, f);
    check("R7 equal limit fault", {29'b0, f}, 32'h0);
    check("R7 equal limit paddr", pa, 32'h1234_50AB);
  endtask

  task automatic t_bad_outer();
    logic [31:0] pa; logic [2:0] f;
    lat = 3;
    walk(va_of(9, 1, 12'h010), 1'b0, 20'hFFFFF, pa, f);
    check("R8 fault", {29'b0, f}, 32'h2);
    check("R8 reads", rd_cnt, 32'd1);
    check("R8 outer addr", rd_addr[0], BASE + 32'd36);
  endtask

  task automatic t_bad_inner();
    logic [31:0] pa; logic [2:0] f;
    lat = 0;
    walk(va_of(3, 7, 12'h010), 1'b0, 20'hFFFFF, pa, f);
    check("R9 fault", {29'b0, f}, 32'h3);
    check("R9 reads", rd_cnt, 32'd2);
    check("R9 paddr", pa, 32'h0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_vaddr = '0;
    rsp_ack = 1'b0; tbl_base = BASE; tbl_limit = '1;
    mem[BASE + 32'd12]  = INNER | 32'h1;
    mem[INNER + 32'd20] = 32'h1234_5001;
    mem[INNER + 32'd24] = 32'hABCD_E003;
    mem[BASE + 32'd36]  = 32'h0030_0002;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_write_ok();
    t_write_ro();
    t_limit();
    t_bad_outer();
    t_bad_inner();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule